// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches one bank of up to 32 already-synchronized GPIO inputs and turns the conditions it sees on them into interrupt requests. Each pin can be set to sense a level or an edge. A level pin can be active-high or active-low. An edge pin can trigger on the rising edge, the falling edge, or both edges. Every detected condition sets a sticky status bit. Software clears a status bit by writing 1 to it.

A per-pin mask stops a status bit from reaching the single interrupt line. Software sets mask bits through one write-only register and clears them through another, and can read the whole mask back. Detection does not stop while a pin is masked. A condition seen while masked therefore raises the interrupt as soon as the pin is unmasked, unless software first clears the stale status bit. The register port is a plain single-cycle write strobe plus a combinational read mux.

Top module: `pin_irq_detect`

Register addresses (3 bits):

| Address | Register | Access |
|---|---|---|
| 0 | status | read / write-1-to-clear |
| 1 | mask | read-only |
| 2 | unmask | write-only |
| 3 | mask-set | write-only |
| 4 | kind | read/write |
| 5 | sense | read/write |
| 6 | both-edges | read/write |
| 7 | unused | reads 0 |

## Requirements
- R1: In the kind register (address 4), a bit at 1 makes that pin edge-sensitive and a bit at 0 makes it level-sensitive. The register reads back at address 4.
- R2: In the sense register (address 5), a bit at 1 selects the rising edge or the high level, and a bit at 0 selects the falling edge or the low level. The register reads back at address 5.
- R3: For an edge pin whose both-edges bit (address 6) is 1, either transition triggers and the sense bit is ignored. For a level pin, the both-edges bit has no effect.
- R4: The mask reads at address 1, and a 1 means the pin is masked. Writing 1 to a bit at address 2 clears that mask bit. Writing 1 to a bit at address 3 sets that mask bit. Bits written as 0 leave the mask unchanged, so writing all ones to address 3 masks every pin. Addresses 2, 3 and 7 read as 0.
- R5: Status bits (address 0) are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: Status keeps latching detected conditions while a pin is masked. Unmasking a pin whose status bit is set raises the interrupt.
- R7: irqOut is the OR over all pins of (status AND NOT mask), taken from the current register state.
- R8: A level pin whose level is still active when its status bit is cleared sets that bit again at the same edge, so the bit reads back as 1.
- R9: If a new event and a write-1-to-clear land on the same bit in the same cycle, the event wins and the bit reads back as 1.
- R10: Reset masks every pin, clears status, and sets the kind, sense and both-edges registers to 0.
- R11: Edge detection compares each pin with its value from the previous cycle. A pin held at a steady value produces no further edge events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Synchronized pin levels |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 3 | Write address |
| wrData | input | NUM_PINS | Write data, one bit per pin |
| rdAddr | input | 3 | Read address |
| rdData | output | NUM_PINS | Combinational read data |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench builds the block with NUM_PINS at its default of 32. This exercises the full-width patterns: the all-ones mask-set write, and clears that touch the top bit as well as the bottom bit. Directed sequences cover several corners:
- an event landing on the same cycle as its clear;
- a level pin that is still active when it is cleared;
- a condition latched while masked and then unmasked;
- both-edges mode on a pin whose sense bit is 0.

A long run of seeded random pin toggles and register writes is then checked every cycle against a bench model of the whole register state.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int REG_ADDR_W = 3;

  // Register addresses
  typedef enum logic [REG_ADDR_W-1:0] {
    ADR_STATUS  = 3'd0,
    ADR_MASK    = 3'd1,
    ADR_UNMASK  = 3'd2,
    ADR_MASKSET = 3'd3,
    ADR_KIND    = 3'd4,
    ADR_SENSE   = 3'd5,
    ADR_BOTH    = 3'd6,
    ADR_SPARE   = 3'd7
  } regAddr_e;

  // Read mux selection
  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_MASK,
    RD_KIND,
    RD_SENSE,
    RD_BOTH
  } rdSel_e;

  // Write strobes from control to datapath
  typedef struct packed {
    logic ldKind;
    logic ldSense;
    logic ldBoth;
    logic clrStat;
    logic maskSet;
    logic maskClr;
  } ctlStrobe_t;

endpackage

// File: rtl/pin_irq_cell.sv
// Per-pin condition detector: purely combinational.
module pin_irq_cell (
  input  logic cur,
  input  logic prev,
  input  logic kind,
  input  logic sense,
  input  logic both,
  output logic hit
);

  logic rise;
  logic fall;

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  always_comb begin
    if (kind) begin
      if (both) begin
        hit = rise | fall;
      end else if (sense) begin
        hit = rise;
      end else begin
        hit = fall;
      end
    end else begin
      hit = sense ? cur : ~cur;
    end
  end

endmodule

// File: rtl/pin_irq_ctrl.sv
// Address decode: write strobes and read selection.
module pin_irq_ctrl
  import pin_irq_pkg::*;
(
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [REG_ADDR_W-1:0] rdAddr,
  output ctlStrobe_t            strb,
  output rdSel_e                rdSel
);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (regAddr_e'(wrAddr))
        ADR_STATUS:  strb.clrStat = 1'b1;
        ADR_UNMASK:  strb.maskClr = 1'b1;
        ADR_MASKSET: strb.maskSet = 1'b1;
        ADR_KIND:    strb.ldKind  = 1'b1;
        ADR_SENSE:   strb.ldSense = 1'b1;
        ADR_BOTH:    strb.ldBoth  = 1'b1;
        default:     strb = '0;
      endcase
    end
  end

  always_comb begin
    case (regAddr_e'(rdAddr))
      ADR_STATUS: rdSel = RD_STATUS;
      ADR_MASK:   rdSel = RD_MASK;
      ADR_KIND:   rdSel = RD_KIND;
      ADR_SENSE:  rdSel = RD_SENSE;
      ADR_BOTH:   rdSel = RD_BOTH;
      default:    rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/pin_irq_datapath.sv
// Configuration, mask and status registers plus per-pin detectors.
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  ctlStrobe_t          strb,
  input  logic [NUM_PINS-1:0] wrData,
  input  rdSel_e              rdSel,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] statusQ,
  output logic [NUM_PINS-1:0] maskQ,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] kindQ;
  logic [NUM_PINS-1:0] senseQ;
  logic [NUM_PINS-1:0] bothQ;
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] hitVec;
  logic [NUM_PINS-1:0] clrVec;
  logic [NUM_PINS-1:0] setMaskVec;
  logic [NUM_PINS-1:0] clrMaskVec;
  logic [NUM_PINS-1:0] statusNext;
  logic [NUM_PINS-1:0] maskNext;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_irq_cell cell_i (
      .cur   (pinIn[i]),
      .prev  (prevQ[i]),
      .kind  (kindQ[i]),
      .sense (senseQ[i]),
      .both  (bothQ[i]),
      .hit   (hitVec[i])
    );
  end

  assign clrVec     = strb.clrStat ? wrData : '0;
  assign setMaskVec = strb.maskSet ? wrData : '0;
  assign clrMaskVec = strb.maskClr ? wrData : '0;

  // A fresh hit outranks a clear on the same bit.
  assign statusNext = (statusQ & ~clrVec) | hitVec;
  assign maskNext   = (maskQ | setMaskVec) & ~clrMaskVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ   <= '0;
      senseQ  <= '0;
      bothQ   <= '0;
      prevQ   <= '0;
      statusQ <= '0;
      maskQ   <= '1;
    end else begin
      prevQ   <= pinIn;
      statusQ <= statusNext;
      maskQ   <= maskNext;
      if (strb.ldKind)  kindQ  <= wrData;
      if (strb.ldSense) senseQ <= wrData;
      if (strb.ldBoth)  bothQ  <= wrData;
    end
  end

  always_comb begin
    case (rdSel)
      RD_STATUS: rdData = statusQ;
      RD_MASK:   rdData = maskQ;
      RD_KIND:   rdData = kindQ;
      RD_SENSE:  rdData = senseQ;
      RD_BOTH:   rdData = bothQ;
      default:   rdData = '0;
    endcase
  end

  assign irqOut = |(statusQ & ~maskQ);

endmodule

// File: rtl/pin_irq_detect.sv
// Top: thin wrapper joining decode and datapath.
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [NUM_PINS-1:0]   wrData,
  input  logic [REG_ADDR_W-1:0] rdAddr,
  output logic [NUM_PINS-1:0]   rdData,
  output logic                  irqOut
);

  ctlStrobe_t          strb;
  rdSel_e              rdSel;
  logic [NUM_PINS-1:0] statusQ;
  logic [NUM_PINS-1:0] maskQ;

  pin_irq_ctrl ctrl_i (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .strb   (strb),
    .rdSel  (rdSel)
  );

  pin_irq_datapath #(.NUM_PINS(NUM_PINS)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .strb    (strb),
    .wrData  (wrData),
    .rdSel   (rdSel),
    .rdData  (rdData),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [REG_ADDR_W-1:0] wrAddr,
  input logic [NUM_PINS-1:0]   wrData,
  input logic [NUM_PINS-1:0]   statusQ,
  input logic [NUM_PINS-1:0]   maskQ,
  input logic                  irqOut
);

  // R5
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == ADR_STATUS) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R4
  unmask_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADR_UNMASK) |=> ((maskQ & $past(wrData)) == '0));

  // R4
  maskset_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADR_MASKSET) |=> ((maskQ & $past(wrData)) == $past(wrData)));

  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (wrAddr == ADR_UNMASK || wrAddr == ADR_MASKSET)) |=> $stable(maskQ));

  // R7
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> !irqOut);

endmodule

bind pin_irq_detect pin_irq_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .statusQ (statusQ),
  .maskQ   (maskQ),
  .irqOut  (irqOut)
);

// File: tb/pin_irq_detect_tb_top.sv
`timescale 1ns/1ps
module pin_irq_detect_tb_top;

  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic          wrEn = 1'b0;
  logic [2:0]    wrAddr = '0;
  logic [NP-1:0] wrData = '0;
  logic [2:0]    rdAddr = '0;
  logic [NP-1:0] rdData;
  logic          irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench model state
  logic [NP-1:0] mKind, mSense, mBoth, mMask, mStat, mPrev;

  always #4 clk = ~clk;

  pin_irq_detect #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [NP-1:0] fHit(input logic [NP-1:0] c, p, k, s, b);
    logic [NP-1:0] e, l;
    e = (b & (c ^ p)) | (~b & s & c & ~p) | (~b & ~s & ~c & p);
    l = (s & c) | (~s & ~c);
    return (k & e) | (~k & l);
  endfunction

  function automatic logic [NP-1:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return mStat;
      3'd1: return mMask;
      3'd4: return mKind;
      3'd5: return mSense;
      3'd6: return mBoth;
      default: return '0;
    endcase
  endfunction

  function automatic string regTag(input logic [2:0] a);
    case (a)
      3'd0: return "R5";
      3'd4: return "R1";
      3'd5: return "R2";
      3'd6: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input logic [NP-1:0] p, input logic we,
                           input logic [2:0] wa, input logic [NP-1:0] wd);
    logic [NP-1:0] hit, clr;
    hit = fHit(p, mPrev, mKind, mSense, mBoth);
    clr = (we && wa == 3'd0) ? wd : '0;
    mStat = (mStat & ~clr) | hit;
    if (we) begin
      case (wa)
        3'd2: mMask = mMask & ~wd;
        3'd3: mMask = mMask | wd;
        3'd4: mKind = wd;
        3'd5: mSense = wd;
        3'd6: mBoth = wd;
        default: ;
      endcase
    end
    mPrev = p;
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cyc(input logic [NP-1:0] p, input logic we, input logic [2:0] wa,
                     input logic [NP-1:0] wd, input logic [2:0] ra);
    pinIn = p; wrEn = we; wrAddr = wa; wrData = wd; rdAddr = ra;
    modelStep(p, we, wa, wd);
    @(posedge clk);
    @(negedge clk);
    chk(regTag(ra), rdData, modelRead(ra));
    chk("R7", {31'b0, irqOut}, {31'b0, |(mStat & ~mMask)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] pins;
    mKind = '0; mSense = '0; mBoth = '0; mMask = '1; mStat = '0; mPrev = '0;
    void'($urandom(32'h1a2b3c));
    repeat (3) @(negedge clk);
    // R10: reset values, observed while reset is held
    rdAddr = 3'd1; #1 chk("R10", rdData, '1);
    rdAddr = 3'd0; #1 chk("R10", rdData, '0);
    rdAddr = 3'd4; #1 chk("R10", rdData, '0);
    rdAddr = 3'd5; #1 chk("R10", rdData, '0);
    rdAddr = 3'd6; #1 chk("R10", rdData, '0);
    chk("R10", {31'b0, irqOut}, '0);
    @(negedge clk);
    rstN = 1'b1;

    // configure rising-edge on all pins
    cyc('0, 1, 3'd4, '1, 3'd4);
    chk("R1", rdData, '1);
    cyc('0, 1, 3'd5, '1, 3'd0);
    cyc('0, 1, 3'd0, '1, 3'd0);
    chk("R5", rdData, '0);
    // R1 rising edge on pin 0, R6 masked so no irq
    cyc(32'h1, 0, 3'd0, '0, 3'd0);
    chk("R1", rdData, 32'h1);
    chk("R6", {31'b0, irqOut}, '0);
    // R11 held high: no retrigger, R5 sticky
    cyc(32'h1, 0, 3'd0, '0, 3'd0);
    chk("R5", rdData, 32'h1);
    cyc(32'h1, 1, 3'd0, 32'h1, 3'd0);
    chk("R11", rdData, '0);
    // R9 event and clear in the same cycle
    cyc(32'h0, 0, 3'd0, '0, 3'd0);
    cyc(32'h1, 1, 3'd0, 32'h1, 3'd0);
    chk("R9", rdData, 32'h1);
    // R6 unmask with pending status fires
    cyc(32'h1, 1, 3'd2, 32'h1, 3'd1);
    chk("R4", rdData, 32'hFFFF_FFFE);
    chk("R6", {31'b0, irqOut}, 32'h1);
    // R4 zero bits leave mask alone
    cyc(32'h1, 1, 3'd3, '0, 3'd1);
    chk("R4", rdData, 32'hFFFF_FFFE);
    cyc(32'h1, 1, 3'd0, 32'h1, 3'd0);
    chk("R7", {31'b0, irqOut}, '0);
    // R2 falling edge on pin 1
    cyc(32'h3, 1, 3'd5, ~32'h2, 3'd0);
    cyc(32'h1, 0, 3'd0, '0, 3'd0);
    chk("R2", rdData & 32'h2, 32'h2);
    // R3 both edges ignore sense=0 on pin 1
    cyc(32'h1, 1, 3'd6, 32'h2, 3'd0);
    cyc(32'h1, 1, 3'd0, 32'h2, 3'd0);
    chk("R3", rdData, '0);
    cyc(32'h3, 0, 3'd0, '0, 3'd0);
    chk("R3", rdData, 32'h2);
    // R3 level mode ignores both-edges bit
    cyc(32'h3, 1, 3'd4, ~32'h2, 3'd0);
    cyc(32'h3, 1, 3'd0, '1, 3'd0);
    chk("R3", rdData, '0);
    // R8 level low still active after clear
    cyc(32'h1, 0, 3'd0, '0, 3'd0);
    chk("R8", rdData, 32'h2);
    cyc(32'h1, 1, 3'd0, 32'h2, 3'd0);
    chk("R8", rdData, 32'h2);
    cyc(32'h3, 1, 3'd0, 32'h2, 3'd0);
    chk("R8", rdData, '0);
    // R4 all-ones mask-set, write-only reads 0
    cyc(32'h3, 1, 3'd3, '1, 3'd1);
    chk("R4", rdData, '1);
    cyc(32'h3, 0, 3'd0, '0, 3'd2);
    chk("R4", rdData, '0);

    // seeded random traffic against the model
    pins = 32'h3;
    for (int n = 0; n < 3000; n++) begin
      logic we;
      pins = pins ^ ($urandom & $urandom & $urandom);
      we = ($urandom % 4) == 0;
      cyc(pins, we, 3'($urandom % 8), $urandom, 3'($urandom % 8));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule